// File: doc/BRIEF.md
# Synchronous Termination Wait-State Generator

This block is the glue between a DRAM sequencer and a processor bus that ends each transfer with an active-low synchronous termination. It runs on a tick clock at twice the bus rate. A phase input marks the ticks that fall in the low half of the bus clock. The edge that ends a high-phase tick is the bus clock's falling edge, called a step. All bus-facing outputs change only at steps. Each output value therefore holds across one low half and the following high half of the bus clock, and is stable at the processor's rising-edge sample.

When the strobe and the chip select are both active at a step, the block raises the access request to the sequencer. After that, a chain of delay states counts bus clocks, but only on steps where the sequencer's acknowledge is high. The chain fires the termination after a number of wait states set jointly by two select inputs. For burst transfers it fires three more times, with a shorter spacing that depends on one of those selects. A CAS-enable output lets the column strobe run for each data beat and drops it for one step after every termination.

A termination request from another peripheral is sampled only at low-phase edges. It is merged onto the same termination output, so only one device drives the processor's termination pin.

Top module: `sterm_waitgen`

## Requirements
- R1: `mem_req` becomes 1 at a step where `as_n` and `cs_n` are both 0. It stays 1 at later steps while `cs_n` is 0, even if `as_n` returns to 1. It becomes 0 at the first step with `cs_n` at 1. A step with `cs_n` 0 but `as_n` 1 does not raise it from 0.
- R2: A step is a rising `clk` edge at which `lo_ph` is 0. `sterm_n`, `cas_en` and `mem_req` change only at steps.
- R3: Number the step that first samples an access as step 0, and hold `seq_ack` at 1 from step 1 onward. The first termination then starts at step 1+W, with W = 4 - `fast_ack` - `skip_wait`: 4 for (0,0), 3 for (0,1) and (1,0), 2 for (1,1).
- R4: If `burst` is 1 at the first termination, three more terminations follow. Each starts 1+B steps after the previous one, with B = 2 - `skip_wait`. If `burst` is 0, the access has one termination.
- R5: Each termination drives `sterm_n` to 0 for exactly one step interval (two ticks), after which it returns to 1.
- R6: A step with `seq_ack` at 0 during the wait does not advance the chain. Each such step delays the termination by one step.
- R7: `cas_en` is 1 from step 1 through the step of the last termination. The exception is the step interval right after each termination, where it is 0. It is 0 at step 0 and after the last termination.
- R8: A step that sees `as_n` at 1 drives `sterm_n` to 1 and `cas_en` to 0 and returns the chain to idle. No termination follows while the strobe stays inactive, and the next access has the full timing of R3.
- R9: `ext_term_n` is sampled only at rising edges where `lo_ph` is 1. A 0 sampled there drives `sterm_n` to 0 for the next step interval. A 0 present only while `lo_ph` is 0 has no effect.
- R10: After reset, `sterm_n` is 1, `cas_en` is 0 and `mem_req` is 0.
- R11: After the last termination of an access, no further termination occurs while the strobe stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_ph | input | 1 | 1 during ticks in the low half of the bus clock |
| as_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Memory chip select, active low |
| seq_ack | input | 1 | Acknowledge from the DRAM sequencer, advances the delay chain |
| fast_ack | input | 1 | Select: removes one normal-access wait state when 1 |
| skip_wait | input | 1 | Select: removes one wait state on normal accesses and on burst beats when 1 |
| burst | input | 1 | Processor requests a four-beat burst |
| ext_term_n | input | 1 | Termination request from another peripheral, active low |
| mem_req | output | 1 | Access request to the sequencer |
| cas_en | output | 1 | Column strobe enable for each data beat |
| sterm_n | output | 1 | Synchronous termination to the processor, active low |

## Verification
The assertions assume the following about the inputs. `lo_ph` alternates on every tick. Inputs change away from clock edges. `burst` is steady for the whole access. The burst spacing is at least one step, so the chain never fires on two consecutive steps. The bench derives `lo_ph` from one tick task and changes every input only at falling `clk` edges. It sets the selects and `burst` before the strobe and holds them until release. It drops the acknowledge only for single steps inside the first wait, and it mixes seeded random select, burst and stall patterns with directed runs of all four select pairs, strobe abort, chip select alone, and external requests placed in each phase.

// File: rtl/sterm_waitgen_pkg.sv
// Shared types and wait-count helpers for the termination wait-state generator.
package sterm_waitgen_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_DONE = 2'd2
    } chain_state_e;

    // Wait states on the first beat: base less one for each select that is set.
    function automatic int normal_waits(input logic fast, input logic skip, input int base);
        return base - int'(fast) - int'(skip);
    endfunction

    // Wait states on each following burst beat: only the skip select shortens it.
    function automatic int beat_waits(input logic skip, input int base);
        return base - int'(skip);
    endfunction

endpackage

// File: rtl/stwg_req.sv
// Access request generator.
// Sets the request at a step where strobe and chip select are both active,
// and holds it while chip select stays active.
// Assumes the step enable marks the bus clock falling edge.
module stwg_req (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic as_n,
    input  logic cs_n,
    output logic mem_req
);

    // Request register: set on strobe plus select, held on select alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req <= 1'b0;
        end else if (step_en) begin
            mem_req <= !cs_n && (!as_n || mem_req);
        end
    end

    // R1: request drops at the step after chip select goes away
    a_r1_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cs_n) |=> !mem_req);

    // R1: a rising request was caused by strobe and select together
    a_r1_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(!as_n && !cs_n));

endmodule

// File: rtl/stwg_chain.sv
// Delay-state chain.
// Counts bus clocks on steps where the sequencer acknowledges, and fires a
// termination after the normal wait count. For bursts it fires again after
// each beat wait count until all beats are done.
// Assumes burst is steady during an access and BEAT_BASE is at least 1.
module stwg_chain
    import sterm_waitgen_pkg::*;
#(
    parameter int NORM_BASE = 4,
    parameter int BEAT_BASE = 2,
    parameter int BEATS     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic as_act,
    input  logic seq_ack,
    input  logic fast_ack,
    input  logic skip_wait,
    input  logic burst,
    output logic fire,
    output logic busy
);

    localparam int MAXW = (NORM_BASE > BEAT_BASE) ? NORM_BASE : BEAT_BASE;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int BW   = (BEATS > 2) ? $clog2(BEATS) : 1;

    chain_state_e   st;
    logic [CW-1:0]  dly;
    logic [BW-1:0]  beat;
    logic           bst_q;
    logic [CW-1:0]  tgt_norm;
    logic [CW-1:0]  tgt_beat;
    logic [CW-1:0]  tgt;
    logic           last_beat;
    logic           more;

    // Target count for the current beat, from the two selects.
    always_comb begin
        tgt_norm  = CW'(normal_waits(fast_ack, skip_wait, NORM_BASE));
        tgt_beat  = CW'(beat_waits(skip_wait, BEAT_BASE));
        tgt       = (beat != '0) ? tgt_beat : tgt_norm;
        last_beat = (beat == BW'(BEATS - 1));
        more      = ((beat == '0) ? burst : bst_q) && !last_beat;
    end

    // Fire and busy decode for the output stage.
    always_comb begin
        fire = step_en && as_act && seq_ack && (st == CH_WAIT) && (dly == tgt);
        busy = as_act && ((st == CH_WAIT) || ((st == CH_IDLE) && seq_ack));
    end

    // Chain state: idle on strobe release, advance only on acknowledged steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CH_IDLE;
            dly   <= '0;
            beat  <= '0;
            bst_q <= 1'b0;
        end else if (step_en) begin
            if (!as_act) begin
                st    <= CH_IDLE;
                dly   <= '0;
                beat  <= '0;
                bst_q <= 1'b0;
            end else begin
                case (st)
                    CH_IDLE: begin
                        if (seq_ack) begin
                            st  <= CH_WAIT;
                            dly <= CW'(1);
                        end
                    end
                    CH_WAIT: begin
                        if (seq_ack) begin
                            if (dly == tgt) begin
                                beat <= beat + BW'(1);
                                dly  <= '0;
                                if (beat == '0) begin
                                    bst_q <= burst;
                                end
                                st <= more ? CH_WAIT : CH_DONE;
                            end else begin
                                dly <= dly + CW'(1);
                            end
                        end
                    end
                    default: st <= CH_DONE;
                endcase
            end
        end
    end

    // R6: a step without acknowledge leaves the wait count and beat unchanged
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && as_act && !seq_ack && st == CH_WAIT) |=> ($stable(dly) && $stable(beat)));

    // R11: once finished, the chain stays finished while the strobe is held
    a_r11_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_DONE && !(step_en && !as_act)) |=> (st == CH_DONE));

endmodule

// File: rtl/stwg_out.sv
// Output stage.
// Samples the foreign termination request at low-phase edges, merges it with
// the chain's fire pulse into the termination output, and drives CAS-enable.
// Assumes fire only occurs on steps and never on two consecutive steps.
module stwg_out (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic lo_ph,
    input  logic as_act,
    input  logic fire,
    input  logic busy,
    input  logic ext_term_n,
    output logic sterm_n,
    output logic cas_en
);

    logic ext_seen;
    logic mem_term_q;

    // Foreign request sampler: accepts the request only while the bus clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_seen <= 1'b0;
        end else if (lo_ph) begin
            ext_seen <= !ext_term_n;
        end
    end

    // Termination and CAS-enable registers, updated once per bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sterm_n    <= 1'b1;
            mem_term_q <= 1'b0;
            cas_en     <= 1'b0;
        end else if (step_en) begin
            sterm_n    <= !(fire || ext_seen);
            mem_term_q <= fire;
            cas_en     <= busy && !mem_term_q;
        end
    end

    // R2: termination changes only at steps
    a_r2_sterm_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(sterm_n));

    // R9: foreign request is captured only in the low phase
    a_r9_ext_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_ph |=> $stable(ext_seen));

    // R5: a memory termination lasts one step interval only
    a_r5_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mem_term_q) |=> !mem_term_q);

    // R7: CAS-enable is off in the interval after each termination
    a_r7_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mem_term_q) |=> !cas_en);

    // R8: releasing the strobe idles both outputs at the next step
    a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !as_act && !ext_seen) |=> (sterm_n && !cas_en));

endmodule

// File: rtl/sterm_waitgen.sv
// Synchronous termination wait-state generator, top level.
// Ties the request generator, delay chain and output stage together.
// Assumes clk runs at twice the bus rate and lo_ph alternates every tick.
module sterm_waitgen #(
    parameter int NORM_BASE = 4,
    parameter int BEAT_BASE = 2,
    parameter int BEATS     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_ph,
    input  logic as_n,
    input  logic cs_n,
    input  logic seq_ack,
    input  logic fast_ack,
    input  logic skip_wait,
    input  logic burst,
    input  logic ext_term_n,
    output logic mem_req,
    output logic cas_en,
    output logic sterm_n
);

    logic step_en;
    logic as_act;
    logic fire;
    logic busy;

    // Step marker and qualified strobe.
    always_comb begin
        step_en = !lo_ph;
        as_act  = !as_n && !cs_n;
    end

    stwg_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .as_n    (as_n),
        .cs_n    (cs_n),
        .mem_req (mem_req)
    );

    stwg_chain #(
        .NORM_BASE (NORM_BASE),
        .BEAT_BASE (BEAT_BASE),
        .BEATS     (BEATS)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .as_act    (as_act),
        .seq_ack   (seq_ack),
        .fast_ack  (fast_ack),
        .skip_wait (skip_wait),
        .burst     (burst),
        .fire      (fire),
        .busy      (busy)
    );

    stwg_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .lo_ph      (lo_ph),
        .as_act     (as_act),
        .fire       (fire),
        .busy       (busy),
        .ext_term_n (ext_term_n),
        .sterm_n    (sterm_n),
        .cas_en     (cas_en)
    );

endmodule

// File: tb/sterm_waitgen_tb.sv
// Bench for the termination wait-state generator: directed and seeded random accesses.
module sterm_waitgen_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_ph = 1'b0;
    logic as_n = 1'b1;
    logic cs_n = 1'b1;
    logic seq_ack = 1'b0;
    logic fast_ack = 1'b0;
    logic skip_wait = 1'b0;
    logic burst = 1'b0;
    logic ext_term_n = 1'b1;
    logic mem_req;
    logic cas_en;
    logic sterm_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    sterm_waitgen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_ph      (lo_ph),
        .as_n       (as_n),
        .cs_n       (cs_n),
        .seq_ack    (seq_ack),
        .fast_ack   (fast_ack),
        .skip_wait  (skip_wait),
        .burst      (burst),
        .ext_term_n (ext_term_n),
        .mem_req    (mem_req),
        .cas_en     (cas_en),
        .sterm_n    (sterm_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One tick: wait for mid-tick, then set the phase of the tick that follows.
    task automatic next_tick();
        @(negedge clk);
        lo_ph = ~lo_ph;
    endtask

    // Leave the bench so the coming rising edge is a step.
    task automatic align_hi();
        next_tick();
        while (lo_ph) next_tick();
    endtask

    function automatic int norm_w(input bit f, input bit s);
        return 4 - int'(f) - int'(s);
    endfunction

    function automatic int beat_w(input bit s);
        return 2 - int'(s);
    endfunction

    function automatic bit is_term(input int n, input int t0, input int bw, input bit b);
        for (int j = 0; j <= (b ? 3 : 0); j++) begin
            if (n == t0 + j * (1 + bw)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit exp_cas(input int n, input int t0, input int bw, input bit b);
        int last;
        last = t0 + (b ? 3 : 0) * (1 + bw);
        if (n < 1 || n > last) return 1'b0;
        if (is_term(n - 1, t0, bw, b)) return 1'b0;
        return 1'b1;
    endfunction

    // Full access with optional single-step acknowledge stall, then release.
    task automatic run_access(input bit f, input bit s, input bit b, input int stall);
        int    w;
        int    bw;
        int    t0;
        int    last;
        bit    et;
        logic  lo_s;
        string tag;
        w  = norm_w(f, s);
        bw = beat_w(s);
        t0 = 1 + w + ((stall >= 2 && stall <= 1 + w) ? 1 : 0);
        last = t0 + (b ? 3 : 0) * (1 + bw);
        align_hi();
        fast_ack = f; skip_wait = s; burst = b;
        as_n = 1'b0; cs_n = 1'b0;
        for (int n = 0; n <= last + 3; n++) begin
            next_tick();
            et = is_term(n, t0, bw, b);
            if (n > last)            tag = "R11";
            else if (stall >= 0)     tag = "R6";
            else if (n > t0)         tag = "R4";
            else                     tag = "R3";
            chk(sterm_n == !et, tag, int'(sterm_n), int'(!et));
            chk(cas_en == exp_cas(n, t0, bw, b), "R7", int'(cas_en), int'(exp_cas(n, t0, bw, b)));
            chk(mem_req == 1'b1, "R1", int'(mem_req), 1);
            lo_s = sterm_n;
            next_tick();
            chk(sterm_n == lo_s, "R5", int'(sterm_n), int'(lo_s));
            seq_ack = (n + 1 == stall) ? 1'b0 : 1'b1;
        end
        as_n = 1'b1; cs_n = 1'b1; seq_ack = 1'b0; burst = 1'b0;
        next_tick();
        chk(sterm_n == 1'b1, "R8", int'(sterm_n), 1);
        chk(cas_en == 1'b0, "R8", int'(cas_en), 0);
        chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
        next_tick();
    endtask

    initial begin
        int seed;
        int r;
        bit f;
        bit s;
        bit b;
        int st;
        seed = 1234;
        r = $urandom(seed);
        repeat (4) next_tick();
        rst_n = 1'b1;
        next_tick();
        next_tick();
        // R10: reset state
        chk(sterm_n == 1'b1, "R10", int'(sterm_n), 1);
        chk(cas_en == 1'b0, "R10", int'(cas_en), 0);
        chk(mem_req == 1'b0, "R10", int'(mem_req), 0);

        // R3/R4: every select pair, single and burst
        for (int k = 0; k < 8; k++) begin
            run_access(k[0], k[1], k[2], -1);
        end

        // R1: chip select without strobe raises no request
        align_hi();
        cs_n = 1'b0; as_n = 1'b1;
        for (int n = 0; n < 3; n++) begin
            next_tick();
            chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
            chk(sterm_n == 1'b1, "R1", int'(sterm_n), 1);
            next_tick();
        end
        cs_n = 1'b1;

        // R8: strobe abort before termination, request held by select
        align_hi();
        fast_ack = 1'b0; skip_wait = 1'b0; burst = 1'b0;
        as_n = 1'b0; cs_n = 1'b0;
        for (int n = 0; n < 3; n++) begin
            next_tick();
            next_tick();
            seq_ack = 1'b1;
        end
        as_n = 1'b1;
        for (int n = 3; n < 9; n++) begin
            next_tick();
            chk(sterm_n == 1'b1, "R8", int'(sterm_n), 1);
            chk(cas_en == 1'b0, "R8", int'(cas_en), 0);
            chk(mem_req == 1'b1, "R1", int'(mem_req), 1);
            next_tick();
        end
        cs_n = 1'b1; seq_ack = 1'b0;
        next_tick();
        chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
        next_tick();
        run_access(1'b0, 1'b0, 1'b0, -1);   // R8: full timing after abort

        // R9: foreign request inside the low phase
        align_hi();
        next_tick();
        ext_term_n = 1'b0;
        next_tick();
        ext_term_n = 1'b1;
        next_tick();
        chk(sterm_n == 1'b0, "R9", int'(sterm_n), 0);
        next_tick();
        chk(sterm_n == 1'b0, "R9", int'(sterm_n), 0);
        next_tick();
        chk(sterm_n == 1'b1, "R9", int'(sterm_n), 1);

        // R9: foreign request only in the high phase is ignored
        align_hi();
        ext_term_n = 1'b0;
        next_tick();
        ext_term_n = 1'b1;
        for (int n = 0; n < 4; n++) begin
            next_tick();
            chk(sterm_n == 1'b1, "R9", int'(sterm_n), 1);
        end

        // R6: directed stall at the last wait step
        run_access(1'b1, 1'b1, 1'b0, 3);

        // Seeded random mix of selects, bursts and stalls
        for (int k = 0; k < 24; k++) begin
            f = 1'($urandom_range(0, 1));
            s = 1'($urandom_range(0, 1));
            b = 1'($urandom_range(0, 1));
            st = -1;
            if ($urandom_range(0, 3) == 0) st = int'($urandom_range(2, 1 + norm_w(f, s)));
            run_access(f, s, b, st);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule